// File: doc/BRIEF.md
# Four-Point Signature Detection Sequencer

This block decides whether the load on a port carries a valid resistance signature. It does this with four measurements. It asks an external measurement front end for two samples under forced current, then for two samples under forced voltage. The front end does the analog forcing and the digitising. For each pair, the block subtracts one sample from the other and divides to get a slope resistance in ohms. Because only the difference is used, a fixed offset such as a series diode drop or a leakage current drops out of the result.

The forced-voltage pair runs only when the forced-current pair has already produced a resistance in the valid band. The final answer is a 3-bit status code. Some conditions end the cycle early, each with its own code:
- the first forced-current voltage is too low, which reads as a short;
- the front end flags an over-voltage;
- the front end flags an excessive capacitance.

The host pulses `start` and waits for the one-cycle `done` pulse. It then reads `result`, which holds its value until the next accepted start.

Top module: `sig_detect_seq`

## Requirements
- R1: After reset, `result` is 0 (unknown) and `done` is low. From the cycle after a start is accepted until `done`, `result` reads 0. `done` is high for exactly one cycle, and `result` then holds until the next accepted start.
- R2: Requests go out in step order 0 and 1 (forced current), then 2 and 3 (forced voltage). `meas_req` stays high and `meas_step` stays stable until `meas_ack` is seen with `meas_req`.
- R3: If the step-0 sample is below `SHORT_MV` millivolts (1000 by default), the cycle ends with code 1 (short) and no further step is requested. A sample of exactly 1000 does not abort.
- R4: The forced-current slope is (v1 - v0) * 1000 / (I_HI_UA - I_LO_UA) ohms, rounded down, with samples in mV. The default current difference is 110 uA. A difference that is zero or negative gives 0 ohms.
- R5: A slope is mapped to a code as follows, with a value on a boundary going to the lower band:
  - up to 2400 ohms: 1 (short);
  - up to 17000 ohms: 3 (signature low);
  - up to 29000 ohms: 4 (good);
  - up to 50000 ohms: 5 (signature high);
  - above 50000 ohms: 6 (open).
- R6: Steps 2 and 3 are requested only if the forced-current slope gives code 4. Otherwise that code is the final result.
- R7: The forced-voltage slope is (V_HI_MV - V_LO_MV) * 1000 / (i3 - i2) ohms, rounded down, with samples in uA. The default voltage difference is 4000 mV. A current difference that is zero or negative counts as open (code 6). The band of this slope is the final result.
- R8: An acknowledged sample that comes with `over_volt` ends the cycle with code 7. One that comes with `cap_high` ends it with code 2. If both flags are set, code 7 wins. Either flag takes priority over the short check and over the resistance bands.
- R9: A `start` pulse while a cycle is running is ignored. The step sequence and the result of that cycle are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a detection cycle (used only when idle) |
| meas_ack | input | 1 | Front end presents a sample this cycle |
| meas_data | input | DATA_W | Sample: voltage in mV (steps 0-1) or current in uA (steps 2-3) |
| cap_high | input | 1 | Excess-capacitance flag, valid with `meas_ack` |
| over_volt | input | 1 | Port over-voltage flag, valid with `meas_ack` |
| meas_req | output | 1 | Request for a measurement at `meas_step` |
| meas_step | output | 2 | Step index 0..3 |
| done | output | 1 | One-cycle end-of-cycle pulse |
| result | output | 3 | Status code (see R5, R8) |

## Verification
A corrupted step counter shows up at the very next request. Either the index the front end sees is out of order, or forced-voltage steps are requested after a failed forced-current pair. A wrong state or code register shows up either as a `result` that leaves 0 while requests are still outstanding, or as a wrong code at the `done` pulse. A divider fault shifts the reported band. This is exposed within one cycle of `done` by cases that sit exactly on each band boundary.

// File: rtl/sdet_pkg.sv
// Shared types for the signature detection sequencer.
// Assumes: codes are observed at the top-level result port as 3-bit values.
package sdet_pkg;
    typedef enum logic [2:0] {
        SD_UNKNOWN  = 3'd0,
        SD_SHORT    = 3'd1,
        SD_CAP_HIGH = 3'd2,
        SD_SIG_LOW  = 3'd3,
        SD_GOOD     = 3'd4,
        SD_SIG_HIGH = 3'd5,
        SD_OPEN     = 3'd6,
        SD_OVERVOLT = 3'd7
    } sd_code_e;
endpackage

// File: rtl/sdet_div.sv
// Restoring unsigned divider, one quotient bit per cycle.
// Assumes: go is a single-cycle pulse while idle. A zero divisor returns
// an all-ones quotient one cycle after go. Otherwise done pulses NUM_W
// cycles after go.
module sdet_div #(
    parameter int NUM_W = 26,
    parameter int DEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DEN_W:0]   trial;
    logic [DEN_W:0]   diff;
    logic             fits;

    // trial step: shift the next dividend bit into the remainder
    always_comb begin
        trial = {rem_q, quo[NUM_W-1]};
        diff  = trial - {1'b0, den_q};
        fits  = (trial >= {1'b0, den_q});
    end

    // load on go, then iterate one bit per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            quo   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                if (den == '0) begin
                    quo   <= '1;
                    cnt_q <= '0;
                    done  <= 1'b1;
                end else begin
                    quo   <= num;
                    rem_q <= '0;
                    den_q <= den;
                    cnt_q <= CNT_W'(NUM_W);
                end
            end else if (cnt_q != '0) begin
                rem_q <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
                quo   <= {quo[NUM_W-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sdet_band.sv
// Maps a slope resistance in ohms to a status code.
// Assumes: a value equal to a limit belongs to the lower band.
module sdet_band
    import sdet_pkg::*;
#(
    parameter int Q_W          = 26,
    parameter int R_SHORT_MAX  = 2400,
    parameter int R_LOW_MAX    = 17000,
    parameter int R_GOOD_MAX   = 29000,
    parameter int R_HIGH_MAX   = 50000
) (
    input  logic [Q_W-1:0] ohms,
    output sd_code_e       code
);
    localparam logic [Q_W-1:0] LIM_SHORT = Q_W'(R_SHORT_MAX);
    localparam logic [Q_W-1:0] LIM_LOW   = Q_W'(R_LOW_MAX);
    localparam logic [Q_W-1:0] LIM_GOOD  = Q_W'(R_GOOD_MAX);
    localparam logic [Q_W-1:0] LIM_HIGH  = Q_W'(R_HIGH_MAX);

    // band comparison, lowest band first
    always_comb begin
        if (ohms <= LIM_SHORT)     code = SD_SHORT;
        else if (ohms <= LIM_LOW)  code = SD_SIG_LOW;
        else if (ohms <= LIM_GOOD) code = SD_GOOD;
        else if (ohms <= LIM_HIGH) code = SD_SIG_HIGH;
        else                       code = SD_OPEN;
    end
endmodule

// File: rtl/sig_detect_seq.sv
// Four-point signature detection sequencer.
// It runs two forced-current steps and then, only on a good slope, two
// forced-voltage steps. It takes the difference of each pair, divides to
// ohms and encodes the band.
// Assumes: the front end holds meas_data and the flags valid during the
// cycle meas_ack is high; meas_ack only answers a raised meas_req.
module sig_detect_seq
    import sdet_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int I_LO_UA     = 165,
    parameter int I_HI_UA     = 275,
    parameter int V_LO_MV     = 4000,
    parameter int V_HI_MV     = 8000,
    parameter int SHORT_MV    = 1000,
    parameter int R_SHORT_MAX = 2400,
    parameter int R_LOW_MAX   = 17000,
    parameter int R_GOOD_MAX  = 29000,
    parameter int R_HIGH_MAX  = 50000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              meas_ack,
    input  logic [DATA_W-1:0] meas_data,
    input  logic              cap_high,
    input  logic              over_volt,
    output logic              meas_req,
    output logic [1:0]        meas_step,
    output logic              done,
    output logic [2:0]        result
);
    localparam int SCALE = 1000;
    localparam int NUM_W = DATA_W + 10;
    localparam logic [DATA_W-1:0] SHORT_LIM = DATA_W'(SHORT_MV);
    localparam logic [DATA_W-1:0] FC_DEN    = DATA_W'(I_HI_UA - I_LO_UA);
    localparam logic [NUM_W-1:0]  FV_NUM    = NUM_W'((V_HI_MV - V_LO_MV) * SCALE);

    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_DIV, ST_FIN} st_e;

    st_e               state;
    logic [1:0]        step;
    logic [DATA_W-1:0] samp_lo;
    sd_code_e          code_q;
    sd_code_e          result_q;
    logic              done_q;
    logic [DATA_W:0]   pair_diff;
    logic              pair_pos;
    logic [NUM_W-1:0]  div_num;
    logic [DATA_W-1:0] div_den;
    logic              div_go;
    logic              div_done;
    logic [NUM_W-1:0]  div_quo;
    sd_code_e          band;

    // operands for the divider from the current sample pair
    always_comb begin
        pair_diff = {1'b0, meas_data} - {1'b0, samp_lo};
        pair_pos  = !pair_diff[DATA_W] && (pair_diff != '0);
        if (!step[1]) begin
            div_num = pair_pos ? NUM_W'(pair_diff[DATA_W-1:0]) * NUM_W'(SCALE) : '0;
            div_den = FC_DEN;
        end else begin
            div_num = FV_NUM;
            div_den = pair_pos ? pair_diff[DATA_W-1:0] : '0;
        end
        div_go = (state == ST_REQ) && meas_ack && !over_volt && !cap_high && step[0];
    end

    sdet_div #(.NUM_W(NUM_W), .DEN_W(DATA_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (div_go),
        .num  (div_num),
        .den  (div_den),
        .done (div_done),
        .quo  (div_quo)
    );

    sdet_band #(
        .Q_W(NUM_W), .R_SHORT_MAX(R_SHORT_MAX), .R_LOW_MAX(R_LOW_MAX),
        .R_GOOD_MAX(R_GOOD_MAX), .R_HIGH_MAX(R_HIGH_MAX)
    ) u_band (
        .ohms(div_quo),
        .code(band)
    );

    // sequencing of steps, early aborts and result publication
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            step     <= 2'd0;
            samp_lo  <= '0;
            code_q   <= SD_UNKNOWN;
            result_q <= SD_UNKNOWN;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    result_q <= SD_UNKNOWN;
                    step     <= 2'd0;
                    state    <= ST_REQ;
                end
                ST_REQ: if (meas_ack) begin
                    if (over_volt) begin
                        code_q <= SD_OVERVOLT;
                        state  <= ST_FIN;
                    end else if (cap_high) begin
                        code_q <= SD_CAP_HIGH;
                        state  <= ST_FIN;
                    end else if ((step == 2'd0) && (meas_data < SHORT_LIM)) begin
                        code_q <= SD_SHORT;
                        state  <= ST_FIN;
                    end else if (!step[0]) begin
                        samp_lo <= meas_data;
                        step    <= step + 2'd1;
                    end else begin
                        state <= ST_DIV;
                    end
                end
                ST_DIV: if (div_done) begin
                    if ((step == 2'd1) && (band == SD_GOOD)) begin
                        step  <= 2'd2;
                        state <= ST_REQ;
                    end else begin
                        code_q <= band;
                        state  <= ST_FIN;
                    end
                end
                default: begin
                    result_q <= code_q;
                    done_q   <= 1'b1;
                    state    <= ST_IDLE;
                end
            endcase
        end
    end

    // port drive
    always_comb begin
        meas_req  = (state == ST_REQ);
        meas_step = step;
        done      = done_q;
        result    = result_q;
    end
endmodule

// File: rtl/sdet_chk.sv
// Protocol and result checker for sig_detect_seq, observing ports only.
// Assumes: bound to every instance of sig_detect_seq.
module sdet_chk #(
    parameter int DATA_W   = 16,
    parameter int SHORT_MV = 1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              meas_ack,
    input logic [DATA_W-1:0] meas_data,
    input logic              cap_high,
    input logic              over_volt,
    input logic              meas_req,
    input logic [1:0]        meas_step,
    input logic              done,
    input logic [2:0]        result
);
    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R1
    busy_unknown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        meas_req |-> (result == 3'd0));
    // R1
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !meas_req);
    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_req && !meas_ack) |=> (meas_req && $stable(meas_step)));
    // R9
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_req && start && !meas_ack && meas_step != 2'd0) |=> (meas_step != 2'd0));
    // R3
    short_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_req && meas_ack && meas_step == 2'd0 && meas_data < DATA_W'(SHORT_MV)
         && !over_volt && !cap_high) |=> !meas_req ##1 (done && result == 3'd1));
    // R8
    overvolt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_req && meas_ack && over_volt) |=> !meas_req ##1 (done && result == 3'd7));
    // R8
    cap_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_req && meas_ack && cap_high && !over_volt) |=> !meas_req ##1 (done && result == 3'd2));
endmodule

bind sig_detect_seq sdet_chk #(.DATA_W(DATA_W), .SHORT_MV(SHORT_MV)) u_chk (.*);

// File: tb/sig_detect_seq_tb.sv
// Bench: acts as the measurement front end, predicts codes behaviourally and
// compares the ports on every falling clock edge.
module sig_detect_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        meas_ack = 1'b0;
    logic [15:0] meas_data = '0;
    logic        cap_high = 1'b0;
    logic        over_volt = 1'b0;
    logic        meas_req;
    logic [1:0]  meas_step;
    logic        done;
    logic [2:0]  result;

    int    checks = 0;
    int    failures = 0;
    bit    in_run = 0;
    bit    finished = 0;
    int    exp_code = 0;
    int    last_code = 0;
    string cur_tag = "";

    always #5 clk = ~clk;

    sig_detect_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .meas_ack(meas_ack),
        .meas_data(meas_data), .cap_high(cap_high), .over_volt(over_volt),
        .meas_req(meas_req), .meas_step(meas_step), .done(done), .result(result)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one cycle; compare ports against the model state on the falling edge
    task automatic tick();
        @(negedge clk);
        if (in_run) begin
            if (done) begin
                chk(result == 3'(exp_code), cur_tag, result, exp_code);
                in_run = 0;
                last_code = exp_code;
            end else begin
                chk(result == 3'd0, "R1 unknown while busy", result, 0);
            end
        end else begin
            chk(done == 1'b0, "R1 done single pulse", done, 0);
            chk(result == 3'(last_code), "R1 result held", result, last_code);
        end
    endtask

    function automatic int band(input longint r);
        if (r <= 2400)  return 1;
        if (r <= 17000) return 3;
        if (r <= 29000) return 4;
        if (r <= 50000) return 5;
        return 6;
    endfunction

    // behavioural prediction of the final code and number of steps requested
    function automatic void model(input int v[4], input bit [3:0] ov, input bit [3:0] cp,
                                  output int code, output int steps);
        longint r;
        int d;
        for (int k = 0; k < 4; k++) begin
            steps = k + 1;
            if (ov[k]) begin code = 7; return; end
            if (cp[k]) begin code = 2; return; end
            if (k == 0 && v[0] < 1000) begin code = 1; return; end
            if (k == 1) begin
                d = v[1] - v[0];
                r = (d <= 0) ? 0 : (longint'(d) * 1000) / 110;
                code = band(r);
                if (code != 4) return;
            end
            if (k == 3) begin
                d = v[3] - v[2];
                r = (d <= 0) ? 64'd1 << 40 : 64'd4000000 / longint'(d);
                code = band(r);
            end
        end
    endfunction

    task automatic run_case(input string tag, input int v0, input int v1, input int i2,
                            input int i3, input bit [3:0] ov, input bit [3:0] cp,
                            input int dly, input bit mid_start);
        int v[4];
        int steps;
        int code;
        int n;
        v[0] = v0; v[1] = v1; v[2] = i2; v[3] = i3;
        model(v, ov, cp, code, steps);
        exp_code = code;
        cur_tag = tag;
        start = 1'b1;
        in_run = 1;
        tick();
        start = 1'b0;
        for (int k = 0; k < steps; k++) begin
            n = 0;
            while (!meas_req && n < 200) begin tick(); n++; end
            chk(meas_req == 1'b1, "R2 request expected", meas_req, 1);
            chk(meas_step == 2'(k), "R2 step order", meas_step, k);
            for (int w = 0; w < dly; w++) begin
                if (mid_start && k == 1 && w == 0) start = 1'b1;
                tick();
                start = 1'b0;
                chk(meas_req && meas_step == 2'(k), "R2 R9 request held", meas_step, k);
            end
            meas_ack = 1'b1;
            meas_data = 16'(v[k]);
            over_volt = ov[k];
            cap_high = cp[k];
            tick();
            meas_ack = 1'b0;
            over_volt = 1'b0;
            cap_high = 1'b0;
            meas_data = '0;
        end
        n = 0;
        while (in_run && n < 200) begin
            chk(meas_req == 1'b0, "R6 no extra step", meas_req, 0);
            tick();
            n++;
        end
        chk(!in_run, "R1 done missing", in_run, 0);
        in_run = 0;
        repeat (2) tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        chk(meas_req == 1'b0, "R1 reset req", meas_req, 0);
        chk(result == 3'd0, "R1 reset result", result, 0);
        chk(done == 1'b0, "R1 reset done", done, 0);

        run_case("R4 R5 R6 R7 good",        1500, 4250, 100, 260, 4'b0, 4'b0, 0, 0);
        run_case("R3 short abort",           800,  4250, 100, 260, 4'b0, 4'b0, 1, 0);
        run_case("R3 boundary 1000 no abort",1000, 3750, 100, 260, 4'b0, 4'b0, 2, 0);
        run_case("R4 small slope short",     1200, 1300, 0,   0,   4'b0, 4'b0, 0, 0);
        run_case("R4 negative slope",        3000, 2000, 0,   0,   4'b0, 4'b0, 1, 0);
        run_case("R5 low",                   1500, 2500, 0,   0,   4'b0, 4'b0, 0, 0);
        run_case("R5 high",                  1500, 5500, 0,   0,   4'b0, 4'b0, 0, 0);
        run_case("R5 open",                  1500, 7500, 0,   0,   4'b0, 4'b0, 0, 0);
        run_case("R5 at 2400",               1500, 1764, 0,   0,   4'b0, 4'b0, 0, 0);
        run_case("R5 at 17000",              1500, 3370, 0,   0,   4'b0, 4'b0, 0, 0);
        run_case("R5 above 17000",           1500, 3371, 100, 260, 4'b0, 4'b0, 0, 0);
        run_case("R5 at 29000",              1500, 4690, 100, 260, 4'b0, 4'b0, 1, 0);
        run_case("R5 above 29000",           1500, 4691, 100, 260, 4'b0, 4'b0, 0, 0);
        run_case("R5 at 50000",              1500, 7000, 0,   0,   4'b0, 4'b0, 0, 0);
        run_case("R5 above 50000",           1500, 7001, 0,   0,   4'b0, 4'b0, 0, 0);
        run_case("R7 fv high",               1500, 4250, 100, 200, 4'b0, 4'b0, 0, 0);
        run_case("R7 fv low",                1500, 4250, 100, 400, 4'b0, 4'b0, 0, 0);
        run_case("R7 fv zero diff",          1500, 4250, 100, 100, 4'b0, 4'b0, 0, 0);
        run_case("R7 fv negative diff",      1500, 4250, 300, 200, 4'b0, 4'b0, 1, 0);
        run_case("R8 overvolt step0",        800,  4250, 0,   0,   4'b0001, 4'b0001, 0, 0);
        run_case("R8 cap step1",             1500, 4250, 0,   0,   4'b0, 4'b0010, 0, 0);
        run_case("R8 cap step2",             1500, 4250, 100, 260, 4'b0, 4'b0100, 1, 0);
        run_case("R8 both step3",            1500, 4250, 100, 260, 4'b1000, 4'b1000, 0, 0);
        run_case("R9 start while busy",      1500, 4250, 100, 260, 4'b0, 4'b0, 2, 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // watchdog: a hung run still ends with the summary line
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule